// File: doc/BRIEF.md
# Endpoint Host-to-Device Address Translator

This block sits at a terminal memory device and turns host physical addresses into device physical addresses. It holds a small number of decoder slots. Each slot describes one window of host address space, the geometry of the whole interleave set that spreads the window over many devices, this device's position in that set, and the device address where the slot's share begins. A request whose address falls in a committed slot's window is claimed only if the chunk it lands in belongs to this device. The chunks owned by the other members are then squeezed out, so the device sees a dense range of its own addresses.

Software programs the slots one field at a time through a write port and then commits them. Commits must go in ascending slot order, and the device ranges must not move backwards. Removing commits goes the other way round. A refused commit or release raises a sticky error flag. Lookups are one request per cycle, and each answer is registered one cycle after its request.

Top module: `ep_hpa_xlate`

## Requirements
- R1: After reset, rspValid, rspHit and cfgErr are low, and no slot is committed, so every lookup misses.
- R2: rspValid is high in the cycle after a cycle with reqValid high and low otherwise, so there is exactly one response per request and a fixed latency of one cycle.
- R3: A slot matches when all of the following hold: it is committed, start <= reqHpa < start + size, and ((reqHpa - start) / gran) mod ways equals its position. Here ways = 2^waysLog and gran = 256 * 2^granLog.
- R4: On a hit, rspDpa = dpaBase + ((reqHpa - start) / (gran * ways)) * gran + ((reqHpa - start) mod gran).
- R5: A response with no matching slot has rspHit low and rspDpa and rspSlot zero.
- R6: A slot that is not committed takes no part in lookups.
- R7: A write with cfgWe high stores the low bits of cfgData into the field chosen by cfgField of slot cfgSlot. The field codes are: 0 window start, 1 window size, 2 log2 of ways (3 bits), 3 log2 of granularity over 256 bytes (4 bits), 4 position (8 bits), 5 device base, 6 commit control (cfgData bit 0: 1 commits, 0 releases), and 7 has no effect. Writes to fields 0 to 5 of a committed slot are ignored.
- R8: A commit of slot k is refused unless all of the following hold: size is nonzero, waysLog <= WAYS_LOG_MAX, granLog <= GRAN_LOG_MAX, and position < ways. For k > 0, slot k-1 must also be committed with dpaBase(k-1) + size(k-1)/ways(k-1) <= dpaBase(k). Committing an already committed slot changes nothing.
- R9: A release of slot k is refused while slot k+1 is committed. Releasing an uncommitted slot changes nothing.
- R10: cfgErr goes high in the cycle after a refused commit or release and stays high until a later write that is not refused, which clears it.
- R11: When several slots match, the lowest-numbered one is used, and rspSlot reports its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Field write strobe |
| cfgSlot | input | SLOT_W | Slot addressed by the write |
| cfgField | input | 3 | Field code (see R7) |
| cfgData | input | 40 | Write data |
| reqValid | input | 1 | Lookup request valid |
| reqHpa | input | 40 | Host physical address to translate |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspHit | output | 1 | A committed slot claimed the address |
| rspSlot | output | SLOT_W | Index of the claiming slot |
| rspDpa | output | 40 | Translated device physical address |
| cfgErr | output | 1 | Sticky flag for a refused commit or release |

## Verification
The bench uses the default build: two slots, up to 16 ways, and granularity from 256 bytes to 16 KiB. With two slots, the ordering rules between neighbours can be tested in both directions. A slot can fail because its predecessor is absent, because the device ranges overlap, or because a release is attempted while the successor is still committed. With two slots, the priority between overlapping windows can also be tested. The geometry runs from the widest set, 16 ways at 256 bytes, down to a single way at the coarsest granularity. This covers the last row of a window, both window edges, and the geometry values just past their limits.

// File: rtl/ep_hpa_xlate_pkg.sv
package ep_hpa_xlate_pkg;
  parameter int ADDR_W        = 40;
  parameter int WL_W          = 3;
  parameter int GL_W          = 4;
  parameter int POS_W         = 8;
  parameter int GRAN_BASE_LOG = 8;

  typedef enum logic [2:0] {
    FLD_START  = 3'd0,
    FLD_SIZE   = 3'd1,
    FLD_WAYS   = 3'd2,
    FLD_GRAN   = 3'd3,
    FLD_POS    = 3'd4,
    FLD_DPA    = 3'd5,
    FLD_COMMIT = 3'd6,
    FLD_RSVD   = 3'd7
  } fieldSel_e;

  typedef struct packed {
    logic [ADDR_W-1:0] start;
    logic [ADDR_W-1:0] size;
    logic [WL_W-1:0]   waysLog;
    logic [GL_W-1:0]   granLog;
    logic [POS_W-1:0]  pos;
    logic [ADDR_W-1:0] dpaBase;
  } slotCfg_t;

  typedef struct packed {
    logic      fieldWe;
    fieldSel_e field;
  } cfgStrobe_t;
endpackage

// File: rtl/ep_hpa_xlate_ctrl.sv
module ep_hpa_xlate_ctrl
  import ep_hpa_xlate_pkg::*;
#(
  parameter int SLOTS        = 2,
  parameter int SLOT_W       = 1,
  parameter int WAYS_LOG_MAX = 4,
  parameter int GRAN_LOG_MAX = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SLOT_W-1:0] cfgSlot,
  input  logic [2:0]        cfgField,
  input  logic [ADDR_W-1:0] cfgData,
  input  slotCfg_t          cfgArr [SLOTS],
  output cfgStrobe_t        strobe,
  output logic [SLOTS-1:0]  committedVec,
  output logic              cfgErr
);
  logic [SLOTS-1:0] geomOk, orderOk, releaseOk;
  logic [ADDR_W:0]  dpaEnd [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_rule
    assign dpaEnd[k] = {1'b0, cfgArr[k].dpaBase} + {1'b0, cfgArr[k].size >> cfgArr[k].waysLog};
    assign geomOk[k] = (cfgArr[k].size != '0)
                    && (int'(cfgArr[k].waysLog) <= WAYS_LOG_MAX)
                    && (int'(cfgArr[k].granLog) <= GRAN_LOG_MAX)
                    && ((cfgArr[k].pos >> cfgArr[k].waysLog) == '0);
    if (k == 0) begin : g_first
      assign orderOk[k] = 1'b1;
    end else begin : g_next
      assign orderOk[k] = committedVec[k-1] && (dpaEnd[k-1] <= {1'b0, cfgArr[k].dpaBase});
    end
    if (k == SLOTS - 1) begin : g_last
      assign releaseOk[k] = 1'b1;
    end else begin : g_inner
      assign releaseOk[k] = !committedVec[k+1];
    end
  end

  fieldSel_e fieldSel;
  logic slotValid, curGeom, curOrder, curRel, curCommitted;
  logic isCommit, setOk, clrOk, refused;

  always_comb begin
    fieldSel     = fieldSel_e'(cfgField);
    slotValid    = 1'b0;
    curGeom      = 1'b0;
    curOrder     = 1'b0;
    curRel       = 1'b0;
    curCommitted = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      if (cfgSlot == SLOT_W'(k)) begin
        slotValid    = 1'b1;
        curGeom      = geomOk[k];
        curOrder     = orderOk[k];
        curRel       = releaseOk[k];
        curCommitted = committedVec[k];
      end
    end
    isCommit = cfgWe && slotValid && (fieldSel == FLD_COMMIT);
    setOk    = isCommit && cfgData[0] && !curCommitted && curGeom && curOrder;
    clrOk    = isCommit && !cfgData[0] && curCommitted && curRel;
    refused  = isCommit && (cfgData[0] ? (!curCommitted && !(curGeom && curOrder))
                                       : (curCommitted && !curRel));
    strobe.fieldWe = cfgWe && slotValid && !curCommitted
                  && (fieldSel != FLD_COMMIT) && (fieldSel != FLD_RSVD);
    strobe.field   = fieldSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      committedVec <= '0;
      cfgErr       <= 1'b0;
    end else begin
      for (int k = 0; k < SLOTS; k++) begin
        if (cfgSlot == SLOT_W'(k)) begin
          if (setOk) committedVec[k] <= 1'b1;
          if (clrOk) committedVec[k] <= 1'b0;
        end
      end
      if (cfgWe) cfgErr <= refused;
    end
  end
endmodule

// File: rtl/ep_hpa_xlate_dpath.sv
module ep_hpa_xlate_dpath
  import ep_hpa_xlate_pkg::*;
#(
  parameter int SLOTS  = 2,
  parameter int SLOT_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [SLOT_W-1:0] cfgSlot,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [SLOTS-1:0]  committedVec,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqHpa,
  output slotCfg_t          cfgArr [SLOTS],
  output logic              rspValid,
  output logic              rspHit,
  output logic [SLOT_W-1:0] rspSlot,
  output logic [ADDR_W-1:0] rspDpa
);
  logic [SLOTS-1:0]  slotHit;
  logic [ADDR_W-1:0] slotDpa [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    slotCfg_t          cfgQ;
    logic [5:0]        gShift;
    logic [ADDR_W-1:0] offset, chunkIdx, rowIdx, waysMask, chunkMask, dpaK;
    logic              hitK;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgQ <= '0;
      end else if (strobe.fieldWe && cfgSlot == SLOT_W'(k)) begin
        case (strobe.field)
          FLD_START: cfgQ.start   <= cfgData;
          FLD_SIZE:  cfgQ.size    <= cfgData;
          FLD_WAYS:  cfgQ.waysLog <= cfgData[WL_W-1:0];
          FLD_GRAN:  cfgQ.granLog <= cfgData[GL_W-1:0];
          FLD_POS:   cfgQ.pos     <= cfgData[POS_W-1:0];
          FLD_DPA:   cfgQ.dpaBase <= cfgData;
          default: ;
        endcase
      end
    end

    always_comb begin
      gShift    = 6'(cfgQ.granLog) + 6'(GRAN_BASE_LOG);
      offset    = reqHpa - cfgQ.start;
      chunkIdx  = offset >> gShift;
      waysMask  = ~({ADDR_W{1'b1}} << cfgQ.waysLog);
      chunkMask = ~({ADDR_W{1'b1}} << gShift);
      rowIdx    = chunkIdx >> cfgQ.waysLog;
      hitK      = committedVec[k] && (reqHpa >= cfgQ.start) && (offset < cfgQ.size)
               && ((chunkIdx & waysMask) == ADDR_W'(cfgQ.pos));
      dpaK      = cfgQ.dpaBase + (rowIdx << gShift) + (offset & chunkMask);
    end

    assign cfgArr[k]  = cfgQ;
    assign slotHit[k] = hitK;
    assign slotDpa[k] = dpaK;
  end

  logic [SLOT_W-1:0] selIdx;
  logic [ADDR_W-1:0] selDpa;
  logic              anyHit;

  always_comb begin
    selIdx = '0;
    selDpa = '0;
    for (int k = SLOTS - 1; k >= 0; k--) begin
      if (slotHit[k]) begin
        selIdx = SLOT_W'(k);
        selDpa = slotDpa[k];
      end
    end
    anyHit = reqValid && (slotHit != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspSlot  <= '0;
      rspDpa   <= '0;
    end else begin
      rspValid <= reqValid;
      rspHit   <= anyHit;
      rspSlot  <= anyHit ? selIdx : '0;
      rspDpa   <= anyHit ? selDpa : '0;
    end
  end
endmodule

// File: rtl/ep_hpa_xlate.sv
module ep_hpa_xlate
  import ep_hpa_xlate_pkg::*;
#(
  parameter int SLOTS        = 2,
  parameter int WAYS_LOG_MAX = 4,
  parameter int GRAN_LOG_MAX = 6,
  localparam int SLOT_W      = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SLOT_W-1:0] cfgSlot,
  input  logic [2:0]        cfgField,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqHpa,
  output logic              rspValid,
  output logic              rspHit,
  output logic [SLOT_W-1:0] rspSlot,
  output logic [ADDR_W-1:0] rspDpa,
  output logic              cfgErr
);
  cfgStrobe_t       strobe;
  slotCfg_t         cfgArr [SLOTS];
  logic [SLOTS-1:0] committedVec;

  ep_hpa_xlate_ctrl #(
    .SLOTS(SLOTS), .SLOT_W(SLOT_W),
    .WAYS_LOG_MAX(WAYS_LOG_MAX), .GRAN_LOG_MAX(GRAN_LOG_MAX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSlot(cfgSlot),
    .cfgField(cfgField), .cfgData(cfgData), .cfgArr(cfgArr),
    .strobe(strobe), .committedVec(committedVec), .cfgErr(cfgErr)
  );

  ep_hpa_xlate_dpath #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgSlot(cfgSlot),
    .cfgData(cfgData), .committedVec(committedVec), .reqValid(reqValid),
    .reqHpa(reqHpa), .cfgArr(cfgArr), .rspValid(rspValid), .rspHit(rspHit),
    .rspSlot(rspSlot), .rspDpa(rspDpa)
  );
endmodule

// File: rtl/ep_hpa_xlate_chk.sv
module ep_hpa_xlate_chk
  import ep_hpa_xlate_pkg::*;
#(
  parameter int SLOTS = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWe,
  input logic              reqValid,
  input logic              rspValid,
  input logic              rspHit,
  input logic [ADDR_W-1:0] rspDpa,
  input logic              cfgErr,
  input logic [SLOTS-1:0]  committedVec
);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  // R1
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> rspValid);
  // R5
  miss_dpa_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspDpa == '0));
  // R6
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && committedVec == '0) |=> !rspHit);
  // R8
  commit_contig_chk: assert property (@(posedge clk) disable iff (!rstN)
    (committedVec & (committedVec + 1'b1)) == '0);
  // R10
  err_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgErr) |-> $past(cfgWe));
  // R10
  err_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgErr) |-> $past(cfgWe));
endmodule

bind ep_hpa_xlate ep_hpa_xlate_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .reqValid(reqValid),
  .rspValid(rspValid), .rspHit(rspHit), .rspDpa(rspDpa),
  .cfgErr(cfgErr), .committedVec(committedVec)
);

// File: tb/sim_ep_hpa_xlate.sv
module sim_ep_hpa_xlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [0:0]  cfgSlot = '0;
  logic [2:0]  cfgField = '0;
  logic [39:0] cfgData = '0;
  logic        reqValid = 1'b0;
  logic [39:0] reqHpa = '0;
  logic        rspValid, rspHit, cfgErr;
  logic [0:0]  rspSlot;
  logic [39:0] rspDpa;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  longint unsigned mStart [2], mSize [2], mBase [2];
  int mWl [2], mGl [2], mPos [2];
  bit mOn [2];

  always #4ns clk = ~clk;

  ep_hpa_xlate u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSlot(cfgSlot), .cfgField(cfgField),
    .cfgData(cfgData), .reqValid(reqValid), .reqHpa(reqHpa), .rspValid(rspValid),
    .rspHit(rspHit), .rspSlot(rspSlot), .rspDpa(rspDpa), .cfgErr(cfgErr)
  );

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrField(int slot, int field, longint unsigned data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSlot = 1'(slot); cfgField = 3'(field); cfgData = 40'(data);
    @(negedge clk);
    cfgWe = 1'b0;
    if (!mOn[slot]) begin
      case (field)
        0: mStart[slot] = data;
        1: mSize[slot]  = data;
        2: mWl[slot]    = int'(data & 7);
        3: mGl[slot]    = int'(data & 15);
        4: mPos[slot]   = int'(data & 255);
        5: mBase[slot]  = data;
        default: ;
      endcase
    end
  endtask

  task automatic setup(int slot, longint unsigned st, longint unsigned sz,
                       int wl, int gl, int pos, longint unsigned base);
    wrField(slot, 0, st); wrField(slot, 1, sz); wrField(slot, 2, wl);
    wrField(slot, 3, gl); wrField(slot, 4, pos); wrField(slot, 5, base);
  endtask

  // Commit (on=1) or release (on=0); checks the error flag expected afterwards.
  task automatic commitChk(string tag, int slot, bit on, bit expErr);
    wrField(slot, 6, on);
    chk({tag, " err"}, cfgErr, expErr);
    if (!expErr) mOn[slot] = on;
  endtask

  function automatic void refSlot(int s, longint unsigned hpa, output bit hit,
                                  output longint unsigned dpa);
    longint unsigned gran, ways, off;
    hit = 0; dpa = 0;
    if (!mOn[s] || hpa < mStart[s]) return;
    off = hpa - mStart[s];
    if (off >= mSize[s]) return;
    gran = 64'd256 << mGl[s];
    ways = 64'd1 << mWl[s];
    if ((off / gran) % ways != longint'(mPos[s])) return;
    hit = 1;
    dpa = mBase[s] + (off / (gran * ways)) * gran + (off % gran);
  endfunction

  task automatic reqPred(string tag, longint unsigned hpa);
    bit h, eh; longint unsigned d, ed; int es;
    eh = 0; ed = 0; es = 0;
    for (int s = 1; s >= 0; s--) begin
      refSlot(s, hpa, h, d);
      if (h) begin eh = 1; ed = d; es = s; end
    end
    @(negedge clk);
    reqValid = 1'b1; reqHpa = 40'(hpa);
    @(negedge clk);
    reqValid = 1'b0;
    chk({tag, " valid"}, rspValid, 1);
    chk({tag, " hit"}, rspHit, eh);
    chk({tag, " dpa"}, rspDpa, ed);
    chk({tag, " slot"}, rspSlot, es);
  endtask

  task automatic tReset();
    chk("R1 rspValid after reset", rspValid, 0);
    chk("R1 rspHit after reset", rspHit, 0);
    chk("R1 cfgErr after reset", cfgErr, 0);
    reqPred("R1 lookup after reset", 64'h1_0000_0510);
    @(negedge clk);
    chk("R2 no response without request", rspValid, 0);
  endtask

  task automatic tUncommitted();
    setup(0, 64'h1_0000_0000, 64'h1_0000_0000, 4, 0, 5, 0);
    setup(1, 64'h3_0000_0000, 64'h2_0000_0000, 1, 2, 1, 64'h0800_0000);
    reqPred("R6 uncommitted slot0", 64'h1_0000_0510);
    commitChk("R8 slot1 without predecessor", 1, 1, 1);
    reqPred("R6 refused slot1", 64'h3_0000_0407);
    commitChk("R10 slot0 commit clears", 0, 1, 0);
  endtask

  task automatic tTranslate();
    reqPred("R4 first row", 64'h1_0000_0510);
    chk("R4 literal dpa", rspDpa, 64'h10);
    reqPred("R4 row three", 64'h1_0000_0000 + 3 * 4096 + 5 * 256 + 255);
    reqPred("R3 other member chunk", 64'h1_0000_0400);
    reqPred("R5 below window", 64'h0_FFFF_FFFF);
    reqPred("R4 last row", 64'h2_0000_0000 - 4096 + 5 * 256);
    chk("R4 last row literal", rspDpa, 64'h0FFF_FF00);
    reqPred("R5 at window end", 64'h2_0000_0000);
  endtask

  task automatic tOrder();
    commitChk("R8 overlapping device range", 1, 1, 1);
    wrField(1, 5, 64'h1000_0000);
    chk("R10 cleared by write", cfgErr, 0);
    commitChk("R8 slot1 in order", 1, 1, 0);
    reqPred("R11 slot1 row0", 64'h3_0000_0407);
    reqPred("R4 slot1 row5", 64'h3_0000_0000 + 5 * 2048 + 1024 + 64'h3FF);
    reqPred("R3 slot1 wrong way", 64'h3_0000_0000 + 2048);
  endtask

  task automatic tLocked();
    wrField(0, 0, 0);
    chk("R7 locked write no error", cfgErr, 0);
    reqPred("R7 locked start kept", 64'h1_0000_0510);
    wrField(0, 7, 64'hFFFF);
    reqPred("R7 reserved field", 64'h1_0000_1510);
  endtask

  task automatic tRelease();
    commitChk("R9 release slot0 blocked", 0, 0, 1);
    reqPred("R9 slot0 still live", 64'h1_0000_0510);
    commitChk("R9 release slot1", 1, 0, 0);
    reqPred("R9 slot1 gone", 64'h3_0000_0407);
    commitChk("R9 release slot0", 0, 0, 0);
    reqPred("R6 slot0 gone", 64'h1_0000_0510);
  endtask

  task automatic tGeometry();
    wrField(0, 2, 1);
    wrField(0, 4, 3);
    commitChk("R8 position beyond ways", 0, 1, 1);
    reqPred("R8 refused geometry", 64'h1_0000_0300);
    wrField(0, 4, 1);
    chk("R10 cleared after refusal", cfgErr, 0);
    wrField(0, 3, 7);
    commitChk("R8 granularity over limit", 0, 1, 1);
    wrField(0, 3, 6);
    wrField(0, 1, 0);
    commitChk("R8 zero size", 0, 1, 1);
  endtask

  task automatic tPriority();
    setup(0, 64'h1000_0000, 64'h1000_0000, 0, 6, 0, 0);
    commitChk("R8 single way slot0", 0, 1, 0);
    setup(1, 64'h1000_0000, 64'h1000_0000, 0, 6, 0, 64'h1000_0000);
    commitChk("R8 abutting device range", 1, 1, 0);
    reqPred("R11 lowest slot wins", 64'h1234_5678);
    chk("R11 literal dpa", rspDpa, 64'h0234_5678);
    reqPred("R5 above both windows", 64'h2000_0000);
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      mStart[s] = 0; mSize[s] = 0; mBase[s] = 0;
      mWl[s] = 0; mGl[s] = 0; mPos[s] = 0; mOn[s] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tUncommitted();
    tTranslate();
    tOrder();
    tLocked();
    tRelease();
    tGeometry();
    tPriority();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule